// File: doc/BRIEF.md
# Memory Sleep Entry and Recovery Controller

This block sits in front of a synchronous memory core and manages its low-power sleep state. A single active-high sleep request, which may arrive asynchronously, is first synchronised. After a fixed entry delay the controller declares the memory asleep. While asleep the controller deselects the core, turns the data output drivers off and gates every command input except the request itself. The controller never clears or resets the core, so stored contents and configuration survive the sleep.

When the request drops, the controller runs a fixed wake-up window before it returns to normal service. In that window it lets reads and deselects through to the core and blocks writes. A write presented while asleep or while waking is dropped and sets a sticky illegal-command flag. The flag is also set by a sleep request that arrives while the core still has operations in flight. The flag clears only on reset.

Top module: `slp_ctrl`

## Requirements
- R1: After reset `sleep_status`, `wake_busy`, `out_disable`, `in_gate` and `illegal_cmd` are all 0. While active, `cmd_go` equals `cmd_valid & cmd_sel`, and `cmd_go_write` equals `cmd_go & cmd_write`.
- R2: If `sleep_req` is first high at rising edge k and stays high, `sleep_status` is still 0 after edge k+3 and is 1 after edge k+4. This is two synchroniser stages plus two entry cycles.
- R3: While `sleep_status` is 1, `out_disable` and `in_gate` are 1, `wake_busy` is 0, and `cmd_go` and `cmd_go_write` are 0 for every command input.
- R4: If `sleep_req` is first low at edge m while asleep, `sleep_status` falls after edge m+2. `wake_busy` is 1 after edges m+2 and m+3 and is 0 after edge m+4, when normal pass-through resumes.
- R5: While `wake_busy` is 1, a selected read (`cmd_write`=0) passes (`cmd_go`=1), and an unselected command gives `cmd_go`=0 and leaves the flag untouched. A selected write is blocked (`cmd_go`=0).
- R6: A valid, selected write seen at an edge while asleep or waking sets `illegal_cmd` after that edge. A read seen while asleep sets nothing.
- R7: Once set, `illegal_cmd` stays 1 until reset, including across later sleep and wake cycles.
- R8: If `ops_busy` is 1 at the edge where the synchronised request first starts entry (edge k+2 for a request first high at edge k), `illegal_cmd` is 1 after that edge.
- R9: A request that is high for only one edge starts entry and then falls back to active. `sleep_status` never rises and commands keep passing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | Sleep request, active high, asynchronous |
| ops_busy | input | 1 | Core still has operations in flight |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_sel | input | 1 | Command selects this device |
| cmd_write | input | 1 | Command is a write (0 = read) |
| cmd_go | output | 1 | Command forwarded to the core |
| cmd_go_write | output | 1 | Forwarded command is a write |
| sleep_status | output | 1 | Device is asleep |
| wake_busy | output | 1 | Wake-up window in progress |
| out_disable | output | 1 | Data output drivers forced to high impedance |
| in_gate | output | 1 | Command inputs gated off |
| illegal_cmd | output | 1 | Sticky illegal-command flag |

## Verification
The request input is driven in three shapes: a long pulse that runs the full sleep and wake sequence, a one-edge pulse that has to abort during entry, and a rise while the core reports busy work. Together they separate the entry count, the exit count and the abort path. Read, write and unselected commands are applied in each phase. This shows whether gating is total while asleep, write-only while waking and absent while active. Repeated sleep cycles after a violation show whether the flag really holds until reset.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        SLP_ACTIVE = 2'd0,
        SLP_ENTER  = 2'd1,
        SLP_SLEEP  = 2'd2,
        SLP_WAKE   = 2'd3
    } slp_state_e;

    function automatic int slp_cnt_width(input int a, input int b);
        int m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.chain = {r_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dout = r_q.chain[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchroniser needs two or more stages");
    end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
#(
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    output logic asleep,
    output logic waking,
    output logic entry_start
);
    localparam int CNT_W = slp_cnt_width(ENTRY_CYCLES, EXIT_CYCLES);
    localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

    typedef struct packed {
        slp_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SLP_ACTIVE: begin
                if (req_s) begin
                    s_d.st  = SLP_ENTER;
                    s_d.cnt = ENTRY_LOAD;
                end
            end
            SLP_ENTER: begin
                if (!req_s) begin
                    s_d.st  = SLP_ACTIVE;
                    s_d.cnt = '0;
                end else if (s_q.cnt == '0) begin
                    s_d.st = SLP_SLEEP;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            SLP_SLEEP: begin
                if (!req_s) begin
                    s_d.st  = SLP_WAKE;
                    s_d.cnt = EXIT_LOAD;
                end
            end
            SLP_WAKE: begin
                if (req_s) begin
                    s_d.st  = SLP_SLEEP;
                    s_d.cnt = '0;
                end else if (s_q.cnt == '0) begin
                    s_d.st = SLP_ACTIVE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SLP_ACTIVE, cnt: '0};
        else        s_q <= s_d;
    end

    assign asleep      = (s_q.st == SLP_SLEEP);
    assign waking      = (s_q.st == SLP_WAKE);
    assign entry_start = (s_q.st == SLP_ACTIVE) && req_s;

    // Sleep is only ever reached while the synchronised request was high.
    assert_entry_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(req_s));

    // The wake window only follows a sleep period.
    assert_wake_after_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(waking) |-> $past(asleep));

    // Asleep and waking never overlap.
    assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({asleep, waking}));

    initial begin
        assert (ENTRY_CYCLES >= 1 && EXIT_CYCLES >= 1) else $error("latencies must be at least one");
    end
endmodule

// File: rtl/slp_guard.sv
module slp_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic asleep,
    input  logic waking,
    input  logic entry_start,
    input  logic ops_busy,
    input  logic cmd_valid,
    input  logic cmd_sel,
    input  logic cmd_write,
    output logic cmd_go,
    output logic cmd_go_write,
    output logic illegal
);
    typedef struct packed {
        logic flag;
    } grd_t;

    grd_t g_d, g_q;
    logic sel_cmd;
    logic bad_write;
    logic bad_entry;

    always_comb begin
        sel_cmd   = cmd_valid && cmd_sel;
        bad_write = sel_cmd && cmd_write && (asleep || waking);
        bad_entry = entry_start && ops_busy;

        cmd_go       = sel_cmd && !asleep && !(waking && cmd_write);
        cmd_go_write = cmd_go && cmd_write;

        g_d = g_q;
        if (bad_write || bad_entry) g_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign illegal = g_q.flag;

    assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(illegal) |-> illegal);

    assert_write_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && cmd_valid && cmd_sel && cmd_write) |=> illegal);

    assert_read_passes_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (waking && cmd_valid && cmd_sel && !cmd_write) |-> cmd_go);

    assert_busy_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_start && ops_busy) |=> illegal);
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl #(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int EXIT_CYCLES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    input  logic ops_busy,
    input  logic cmd_valid,
    input  logic cmd_sel,
    input  logic cmd_write,
    output logic cmd_go,
    output logic cmd_go_write,
    output logic sleep_status,
    output logic wake_busy,
    output logic out_disable,
    output logic in_gate,
    output logic illegal_cmd
);
    logic req_s;
    logic asleep;
    logic waking;
    logic entry_start;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sleep_req),
        .dout (req_s)
    );

    slp_seq #(.ENTRY_CYCLES(ENTRY_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_s),
        .asleep     (asleep),
        .waking     (waking),
        .entry_start(entry_start)
    );

    slp_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .asleep      (asleep),
        .waking      (waking),
        .entry_start (entry_start),
        .ops_busy    (ops_busy),
        .cmd_valid   (cmd_valid),
        .cmd_sel     (cmd_sel),
        .cmd_write   (cmd_write),
        .cmd_go      (cmd_go),
        .cmd_go_write(cmd_go_write),
        .illegal     (illegal_cmd)
    );

    assign sleep_status = asleep;
    assign wake_busy    = waking;
    assign out_disable  = asleep;
    assign in_gate      = asleep;

    // Nothing reaches the core while the outputs are disabled.
    assert_no_cmd_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> !cmd_go && !cmd_go_write);
endmodule

// File: tb/sim_slp_ctrl.sv
module sim_slp_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, ops_busy = 1'b0;
    logic cmd_valid = 1'b0, cmd_sel = 1'b0, cmd_write = 1'b0;
    logic cmd_go, cmd_go_write, sleep_status, wake_busy, out_disable, in_gate, illegal_cmd;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slp_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .ops_busy(ops_busy),
        .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_write(cmd_write),
        .cmd_go(cmd_go), .cmd_go_write(cmd_go_write), .sleep_status(sleep_status),
        .wake_busy(wake_busy), .out_disable(out_disable), .in_gate(in_gate),
        .illegal_cmd(illegal_cmd)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s : actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic v, input logic s, input logic w);
        cmd_valid = v; cmd_sel = s; cmd_write = w;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sleep_req = 1'b0; ops_busy = 1'b0; cmd(0, 0, 0);
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    // Go from active to asleep: request high, five edges.
    task automatic enter_sleep();
        sleep_req = 1'b1;
        step(5);
    endtask

    task automatic t_reset();
        do_reset();
        chk(sleep_status, 1'b0, "R1 sleep_status after reset");
        chk(wake_busy,    1'b0, "R1 wake_busy after reset");
        chk(out_disable,  1'b0, "R1 out_disable after reset");
        chk(in_gate,      1'b0, "R1 in_gate after reset");
        chk(illegal_cmd,  1'b0, "R1 illegal_cmd after reset");
    endtask

    task automatic t_active_pass();
        do_reset();
        cmd(1, 1, 0); #1;
        chk(cmd_go, 1'b1, "R1 read passes when active");
        chk(cmd_go_write, 1'b0, "R1 read not a write");
        cmd(1, 1, 1); #1;
        chk(cmd_go_write, 1'b1, "R1 write passes when active");
        cmd(1, 0, 1); #1;
        chk(cmd_go, 1'b0, "R1 unselected blocked");
        cmd(0, 1, 1); #1;
        chk(cmd_go, 1'b0, "R1 invalid blocked");
        cmd(0, 0, 0);
        step(1);
        chk(illegal_cmd, 1'b0, "R1 no flag from active writes");
    endtask

    task automatic t_entry_and_sleep();
        do_reset();
        sleep_req = 1'b1;
        step(4);
        chk(sleep_status, 1'b0, "R2 not asleep after edge k+3");
        step(1);
        chk(sleep_status, 1'b1, "R2 asleep after edge k+4");
        chk(out_disable, 1'b1, "R3 outputs disabled");
        chk(in_gate, 1'b1, "R3 inputs gated");
        chk(wake_busy, 1'b0, "R3 not waking while asleep");
        cmd(1, 1, 0); #1;
        chk(cmd_go, 1'b0, "R3 read blocked asleep");
        step(1);
        chk(illegal_cmd, 1'b0, "R6 read asleep sets no flag");
        cmd(1, 1, 1); #1;
        chk(cmd_go_write, 1'b0, "R3 write blocked asleep");
        step(1);
        cmd(0, 0, 0);
        chk(illegal_cmd, 1'b1, "R6 write asleep sets flag");
    endtask

    task automatic t_wake();
        do_reset();
        enter_sleep();
        sleep_req = 1'b0;
        step(2);
        chk(sleep_status, 1'b1, "R4 still asleep after edge m+1");
        step(1);
        chk(sleep_status, 1'b0, "R4 sleep drops after edge m+2");
        chk(wake_busy, 1'b1, "R4 waking after edge m+2");
        cmd(1, 1, 0); #1;
        chk(cmd_go, 1'b1, "R5 read passes while waking");
        cmd(1, 0, 1); #1;
        chk(cmd_go, 1'b0, "R5 unselected blocked while waking");
        step(1);
        chk(wake_busy, 1'b1, "R4 waking after edge m+3");
        chk(illegal_cmd, 1'b0, "R5 unselected sets no flag");
        cmd(1, 1, 1); #1;
        chk(cmd_go, 1'b0, "R5 write blocked while waking");
        step(1);
        cmd(0, 0, 0);
        chk(wake_busy, 1'b0, "R4 wake done after edge m+4");
        chk(illegal_cmd, 1'b1, "R6 write while waking sets flag");
        cmd(1, 1, 1); #1;
        chk(cmd_go_write, 1'b1, "R4 writes pass after wake");
        cmd(0, 0, 0);
    endtask

    task automatic t_sticky();
        do_reset();
        enter_sleep();
        cmd(1, 1, 1);
        step(1);
        cmd(0, 0, 0);
        sleep_req = 1'b0;
        step(8);
        chk(illegal_cmd, 1'b1, "R7 flag holds after wake");
        enter_sleep();
        sleep_req = 1'b0;
        step(8);
        chk(illegal_cmd, 1'b1, "R7 flag holds across second sleep");
        do_reset();
        chk(illegal_cmd, 1'b0, "R7 flag cleared by reset");
    endtask

    task automatic t_busy();
        do_reset();
        ops_busy = 1'b1;
        sleep_req = 1'b1;
        step(2);
        chk(illegal_cmd, 1'b0, "R8 no flag before entry edge");
        step(1);
        chk(illegal_cmd, 1'b1, "R8 flag after busy entry");
        ops_busy = 1'b0;
        sleep_req = 1'b0;
        step(8);
    endtask

    task automatic t_abort();
        do_reset();
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            chk(sleep_status, 1'b0, "R9 short pulse never sleeps");
        end
        cmd(1, 1, 1); #1;
        chk(cmd_go_write, 1'b1, "R9 commands pass after abort");
        cmd(0, 0, 0);
        chk(illegal_cmd, 1'b0, "R9 abort sets no flag");
    endtask

    initial begin
        t_reset();
        t_active_pass();
        t_entry_and_sleep();
        t_wake();
        t_sticky();
        t_busy();
        t_abort();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog expired : actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule